// File: doc/BRIEF.md
# Power-Management Event Status Register

This block collects a small set of fixed power-management events into a sticky status word and turns them into one system control interrupt. Five hardware sources can set status bits:
- the top bit of a built-in free-running counter toggling,
- a bus-master request,
- a firmware attention request,
- a power-button press,
- a sleep-button press.

Software reads the status word over a simple request/acknowledge register bus. It clears a bit by writing a one to that bit.

A second word, the enable register, has the same bit layout. It decides which status bits drive the interrupt. The interrupt output is registered. The bus-master bit is recorded but has no path to the interrupt.

The register bus is handled by a three-state machine:
- **BUS_IDLE**: the bus is ready. A request is accepted here.
- **BUS_RD_RESP**: holds the read data while acknowledge is high.
- **BUS_WR_ACK**: acknowledges a write that was applied on the accepting edge.

The transitions are:
- **accept-read**: BUS_IDLE to BUS_RD_RESP.
- **accept-write**: BUS_IDLE to BUS_WR_ACK.
- **respond-done**: either response state back to BUS_IDLE after one cycle.

Top module: `pmevt_status_top`

## Requirements
- R1: After reset, the status word, the enable word and `sci_irq` are all zero. `bus_ready` is 1 and `bus_ack` is 0.
- R2: Bus handshake:
  - A request seen with `bus_ready` high is accepted on that clock edge.
  - In the next cycle `bus_ack` is 1 and `bus_ready` is 0, for exactly one cycle.
  - On a read, `bus_rdata` then carries the word addressed: address 0 gives the status word, address 1 gives the enable word, and addresses 2 and 3 give zero.
- R3: The internal counter is `CNT_W` bits wide (24 or 32). It starts at `CNT_INIT` and adds one on each clock edge where `tick_en` is 1. Status bit 0 is set on the edge where the counter's top bit changes, in either direction. No other edge sets it.
- R4: Status bit 4 is set on any clock edge where `evt_bus_master` is 1.
- R5: Status bit 5 is set on any clock edge where `evt_fw_attn` is 1.
- R6: Status bit 8 is set on any clock edge where `evt_pwr_button` is 1. Status bit 9 is set on any clock edge where `evt_slp_button` is 1.
- R7: Status bits are sticky:
  - A write to address 0 clears exactly the bits written as 1.
  - Bits written as 0 keep their value.
  - Writes to addresses 2 and 3 change nothing.
- R8: If a hardware event and a clearing write hit the same status bit on the same edge, the bit ends up set.
- R9: Status bits 1–3, 6, 7 and 10–15 always read as zero. Enable bits 1–4, 6, 7 and 10–15 always read as zero.
- R10: The enable word is written at address 1 and reads back the implemented bits 0, 5, 8 and 9.
- R11: `sci_irq` is registered. In each cycle it equals the OR, over bits 0, 5, 8 and 9, of status AND enable as they stood one cycle earlier. Bit 4 never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter increment strobe |
| evt_bus_master | input | 1 | Bus-master request event |
| evt_fw_attn | input | 1 | Firmware attention event |
| evt_pwr_button | input | 1 | Power-button press event |
| evt_slp_button | input | 1 | Sleep-button press event |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 16 | Write data |
| bus_ready | output | 1 | Block can accept a request |
| bus_ack | output | 1 | Response cycle |
| bus_rdata | output | 16 | Read data, valid with `bus_ack` after a read |
| sci_irq | output | 1 | Registered interrupt |

## Verification
The hardest case to reach from the ports is the counter's top bit changing. With a 24-bit counter the first change is 2^23 ticks away, and a change in the other direction needs the same distance again. The bench therefore builds two instances that share every input:
- a 24-bit one started 16 ticks below its rising top-bit edge;
- a 32-bit one started 16 ticks below its wrap, which gives a falling edge.

Both are expected to report the timer bit on exactly the 16th tick, with idle cycles between ticks. The set-versus-clear collision is reached by raising a button event in the same cycle as the accepted clearing write.

// File: rtl/pmevt_pkg.sv
package pmevt_pkg;

    localparam int PM_REG_W = 16;
    typedef logic [PM_REG_W-1:0] pm_word_t;

    localparam int BIT_TMR = 0;
    localparam int BIT_BM  = 4;
    localparam int BIT_GBL = 5;
    localparam int BIT_PWR = 8;
    localparam int BIT_SLP = 9;

    localparam pm_word_t STS_IMPL = pm_word_t'((1 << BIT_TMR) | (1 << BIT_BM) |
                                               (1 << BIT_GBL) | (1 << BIT_PWR) |
                                               (1 << BIT_SLP));
    localparam pm_word_t EN_IMPL  = STS_IMPL & ~pm_word_t'(1 << BIT_BM);

    localparam int ADDR_STS = 0;
    localparam int ADDR_EN  = 1;

    typedef enum logic [1:0] {
        BUS_IDLE    = 2'd0,
        BUS_RD_RESP = 2'd1,
        BUS_WR_ACK  = 2'd2
    } bus_state_e;

endpackage

// File: rtl/pmevt_timer.sv
module pmevt_timer #(
    parameter int              CNT_W    = 24,
    parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    output logic msb,
    output logic toggle
);
    localparam int MSB = CNT_W - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_INIT;
        end else if (tick_en) begin
            cnt_q <= cnt_inc;
        end
    end

    // Either direction of the top bit counts as an event.
    assign toggle = tick_en & (cnt_q[MSB] ^ cnt_inc[MSB]);
    assign msb    = cnt_q[MSB];

endmodule

// File: rtl/pmevt_status_bank.sv
module pmevt_status_bank
    import pmevt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pm_word_t set_vec,
    input  pm_word_t clr_vec,
    input  logic     en_we,
    input  pm_word_t en_wdata,
    output pm_word_t sts_q,
    output pm_word_t en_q,
    output logic     irq_q
);
    for (genvar i = 0; i < PM_REG_W; i++) begin : g_bit
        if (STS_IMPL[i]) begin : g_sts
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sts_q[i] <= 1'b0;
                end else if (set_vec[i]) begin
                    sts_q[i] <= 1'b1;
                end else if (clr_vec[i]) begin
                    sts_q[i] <= 1'b0;
                end
            end
        end else begin : g_sts_rsvd
            assign sts_q[i] = 1'b0;
        end

        if (EN_IMPL[i]) begin : g_en
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_q[i] <= 1'b0;
                end else if (en_we) begin
                    en_q[i] <= en_wdata[i];
                end
            end
        end else begin : g_en_rsvd
            assign en_q[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(sts_q & en_q & EN_IMPL);
        end
    end

endmodule

// File: rtl/pmevt_bus_fsm.sv
module pmevt_bus_fsm
    import pmevt_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  pm_word_t          bus_wdata,
    input  pm_word_t          sts_q,
    input  pm_word_t          en_q,
    output logic              bus_ready,
    output logic              bus_ack,
    output pm_word_t          bus_rdata,
    output pm_word_t          clr_vec,
    output logic              en_we,
    output pm_word_t          en_wdata
);
    bus_state_e state_q, state_d;
    pm_word_t   rdata_q, rd_sel;
    logic       accept, hit_sts, hit_en;

    assign hit_sts = (bus_addr == ADDR_W'(ADDR_STS));
    assign hit_en  = (bus_addr == ADDR_W'(ADDR_EN));
    assign accept  = (state_q == BUS_IDLE) && bus_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (accept) state_d = bus_we ? BUS_WR_ACK : BUS_RD_RESP;
            end
            BUS_RD_RESP: state_d = BUS_IDLE;
            BUS_WR_ACK:  state_d = BUS_IDLE;
            default:     state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        if (hit_sts)     rd_sel = sts_q;
        else if (hit_en) rd_sel = en_q;
        else             rd_sel = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (accept && !bus_we) begin
            rdata_q <= rd_sel;
        end
    end

    always_comb begin
        bus_ready = 1'b0;
        bus_ack   = 1'b0;
        bus_rdata = '0;
        unique case (state_q)
            BUS_IDLE:    bus_ready = 1'b1;
            BUS_RD_RESP: begin
                bus_ack   = 1'b1;
                bus_rdata = rdata_q;
            end
            BUS_WR_ACK:  bus_ack = 1'b1;
            default:     bus_ready = 1'b0;
        endcase
    end

    assign clr_vec  = (accept && bus_we && hit_sts) ? bus_wdata : '0;
    assign en_we    = accept && bus_we && hit_en;
    assign en_wdata = bus_wdata;

endmodule

// File: rtl/pmevt_status_top.sv
module pmevt_status_top
    import pmevt_pkg::*;
#(
    parameter int               CNT_W    = 24,
    parameter logic [CNT_W-1:0] CNT_INIT = '0,
    parameter int               ADDR_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              evt_bus_master,
    input  logic              evt_fw_attn,
    input  logic              evt_pwr_button,
    input  logic              evt_slp_button,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic              bus_ready,
    output logic              bus_ack,
    output logic [15:0]       bus_rdata,
    output logic              sci_irq
);
    pm_word_t set_vec, clr_vec, sts_q, en_q, en_wdata;
    logic     en_we, tmr_msb, tmr_toggle;

    pmevt_timer #(
        .CNT_W    (CNT_W),
        .CNT_INIT (CNT_INIT)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_en(tick_en),
        .msb    (tmr_msb),
        .toggle (tmr_toggle)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[BIT_TMR] = tmr_toggle;
        set_vec[BIT_BM]  = evt_bus_master;
        set_vec[BIT_GBL] = evt_fw_attn;
        set_vec[BIT_PWR] = evt_pwr_button;
        set_vec[BIT_SLP] = evt_slp_button;
    end

    pmevt_bus_fsm #(
        .ADDR_W (ADDR_W)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .sts_q    (sts_q),
        .en_q     (en_q),
        .bus_ready(bus_ready),
        .bus_ack  (bus_ack),
        .bus_rdata(bus_rdata),
        .clr_vec  (clr_vec),
        .en_we    (en_we),
        .en_wdata (en_wdata)
    );

    pmevt_status_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .en_we   (en_we),
        .en_wdata(en_wdata),
        .sts_q   (sts_q),
        .en_q    (en_q),
        .irq_q   (sci_irq)
    );

endmodule

// File: rtl/pmevt_status_chk.sv
module pmevt_status_chk
    import pmevt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic     clk,
    input logic     rst_n,
    input logic     bus_req,
    input logic     bus_ready,
    input logic     bus_ack,
    input pm_word_t sts_q,
    input pm_word_t en_q,
    input pm_word_t set_vec,
    input pm_word_t clr_vec,
    input logic     tmr_msb,
    input logic     sci_irq
);
    initial begin
        a_r3_width_legal: assert (CNT_W == 24 || CNT_W == 32);
    end

    a_r2_ack_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ready) |=> (bus_ack && !bus_ready));

    a_r2_ready_ack_apart: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> !bus_ack);

    a_r3_msb_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_msb != $past(tmr_msb)) |-> sts_q[BIT_TMR]);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(sts_q) & ~$past(clr_vec)) & ~sts_q) == '0));

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(set_vec) & STS_IMPL) & ~sts_q) == '0));

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_q & ~STS_IMPL) == '0) && ((en_q & ~EN_IMPL) == '0));

    a_r11_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sci_irq == |($past(sts_q) & $past(en_q) & EN_IMPL)));

endmodule

bind pmevt_status_top pmevt_status_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_ready(bus_ready),
    .bus_ack  (bus_ack),
    .sts_q    (sts_q),
    .en_q     (en_q),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .tmr_msb  (tmr_msb),
    .sci_irq  (sci_irq)
);

// File: tb/pmevt_status_top_tb.sv
module pmevt_status_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        evt_bm = 1'b0, evt_fw = 1'b0, evt_pwr = 1'b0, evt_slp = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        ready_a, ack_a, irq_a, ready_b, ack_b, irq_b;
    logic [15:0] rdata_a, rdata_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_read;
        logic [15:0] exp;
        string       tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // 24-bit instance: top bit rises on the 16th tick
    pmevt_status_top #(.CNT_W(24), .CNT_INIT(24'h7FFFF0), .ADDR_W(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .evt_bus_master(evt_bm), .evt_fw_attn(evt_fw),
        .evt_pwr_button(evt_pwr), .evt_slp_button(evt_slp),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(ready_a), .bus_ack(ack_a), .bus_rdata(rdata_a), .sci_irq(irq_a));

    // 32-bit instance: top bit falls (wrap) on the 16th tick
    pmevt_status_top #(.CNT_W(32), .CNT_INIT(32'hFFFFFFF0), .ADDR_W(2)) u_dut32 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .evt_bus_master(evt_bm), .evt_fw_attn(evt_fw),
        .evt_pwr_button(evt_pwr), .evt_slp_button(evt_slp),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(ready_b), .bus_ack(ack_b), .bus_rdata(rdata_b), .sci_irq(irq_b));

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: pops one expected item per response cycle
    always @(negedge clk) begin
        if (rst_n && !done && (ack_a || ack_b)) begin
            check("R2 ack both instances", {14'd0, ack_a, ack_b}, 16'h0003);
            check("R2 ready low in response", {14'd0, ready_a, ready_b}, 16'h0000);
            if (sb_q.size() == 0) begin
                check("R2 unexpected ack", 16'h0001, 16'h0000);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                if (it.is_read) begin
                    check({it.tag, " (24-bit)"}, rdata_a, it.exp);
                    check({it.tag, " (32-bit)"}, rdata_b, it.exp);
                end
            end
        end
    end

    task automatic bus_op(input bit we, input logic [1:0] a, input logic [15:0] d,
                          input logic [15:0] exp, input string tag);
        exp_item_t it;
        it.is_read = !we;
        it.exp     = exp;
        it.tag     = tag;
        sb_q.push_back(it);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
        bus_op(1'b0, a, 16'h0000, exp, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_op(1'b1, a, d, 16'h0000, "write");
    endtask

    task automatic pulse(input logic [3:0] which);
        {evt_slp, evt_pwr, evt_fw, evt_bm} = which;
        @(negedge clk);
        {evt_slp, evt_pwr, evt_fw, evt_bm} = 4'b0000;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        check({tag, " irq 24-bit"}, {15'd0, irq_a}, {15'd0, exp});
        check({tag, " irq 32-bit"}, {15'd0, irq_b}, {15'd0, exp});
    endtask

    task automatic finish_sim();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ready", {14'd0, ready_a, ready_b}, 16'h0003);
        check("R1 ack", {14'd0, ack_a, ack_b}, 16'h0000);
        chk_irq(1'b0, "R1");
        rd(2'd0, 16'h0000, "R1 status after reset");
        rd(2'd1, 16'h0000, "R1 enable after reset");

        // R10 / R9 enable read-back
        wr(2'd1, 16'hFFFF);
        rd(2'd1, 16'h0321, "R10 R9 enable implemented bits");

        // R4 bus master, no irq path (R11)
        pulse(4'b0001);
        chk_irq(1'b0, "R11 bit4 no irq a");
        @(negedge clk);
        chk_irq(1'b0, "R11 bit4 no irq b");
        rd(2'd0, 16'h0010, "R4 bus master status");
        wr(2'd0, 16'h0000);
        rd(2'd0, 16'h0010, "R7 zero write keeps bit");
        wr(2'd0, 16'h0010);
        rd(2'd0, 16'h0000, "R7 one write clears bit");

        // R6 buttons, R11 registered irq
        pulse(4'b0100);
        chk_irq(1'b0, "R11 irq one cycle late");
        @(negedge clk);
        chk_irq(1'b1, "R11 irq after power button");
        rd(2'd0, 16'h0100, "R6 power button status");
        pulse(4'b1000);
        rd(2'd0, 16'h0300, "R6 sleep button status");
        wr(2'd0, 16'h0100);
        rd(2'd0, 16'h0200, "R7 selective clear");
        chk_irq(1'b1, "R11 irq held by sleep bit");
        wr(2'd0, 16'h0200);
        chk_irq(1'b0, "R11 irq drops after clear");
        rd(2'd0, 16'h0000, "R7 all clear");

        // R5 firmware attention and enable gating
        pulse(4'b0010);
        @(negedge clk);
        chk_irq(1'b1, "R5 irq from firmware bit");
        rd(2'd0, 16'h0020, "R5 firmware status");
        wr(2'd1, 16'h0000);
        chk_irq(1'b0, "R11 enable gating");
        rd(2'd0, 16'h0020, "R7 status kept while disabled");
        wr(2'd1, 16'h0020);
        chk_irq(1'b1, "R11 re-enable");
        wr(2'd0, 16'h0020);
        chk_irq(1'b0, "R11 cleared");

        // R7 / R2 unmapped address
        wr(2'd3, 16'hFFFF);
        rd(2'd0, 16'h0000, "R7 unmapped write status");
        rd(2'd1, 16'h0020, "R7 unmapped write enable");
        rd(2'd3, 16'h0000, "R2 unmapped read zero");
        rd(2'd2, 16'h0000, "R2 address 2 read zero");

        // R8 set wins against a same-cycle clear
        begin
            exp_item_t it;
            it.is_read = 1'b0; it.exp = 16'h0000; it.tag = "write";
            sb_q.push_back(it);
            bus_req = 1'b1; bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h0200;
            evt_slp = 1'b1;
            @(negedge clk);
            bus_req = 1'b0; bus_we = 1'b0; evt_slp = 1'b0;
            @(negedge clk);
        end
        rd(2'd0, 16'h0200, "R8 set wins over clear");
        wr(2'd0, 16'h0200);
        rd(2'd0, 16'h0000, "R8 later clear works");

        // R3 timer top-bit transitions (rise in 24-bit, fall in 32-bit)
        wr(2'd1, 16'h0001);
        ticks(15);
        rd(2'd0, 16'h0000, "R3 no event before top-bit change");
        chk_irq(1'b0, "R3 no timer irq yet");
        ticks(1);
        chk_irq(1'b1, "R3 timer irq on 16th tick");
        rd(2'd0, 16'h0001, "R3 timer status on 16th tick");
        wr(2'd0, 16'h0001);
        ticks(10);
        rd(2'd0, 16'h0000, "R3 no event without top-bit change");
        chk_irq(1'b0, "R3 irq low after clear");

        repeat (2) @(negedge clk);
        check("R2 scoreboard drained", 16'(sb_q.size()), 16'h0000);
        finish_sim();
    end

endmodule